// File: doc/BRIEF.md
# SCI Interrupt Selector

This block takes the single system-control interrupt (SCI) level produced by power-management logic and steers it onto one of five possible interrupt inputs. Two of these are on the APIC side and three are legacy controller pins. A control byte, written through a simple write port, holds the target select code and the ACPI enable bit. The block presents the chosen target pin number with a valid flag, a flag that says whether the pin belongs to the APIC range, and the level to drive on that pin. The interrupt router merges this level with its other sources. That merge is not part of this block.

When the select code changes while the SCI is asserted, the block drops the level on the old pin for one cycle. It then raises the level on the new pin. No target ever sees the assertion on two pins at once. The ACPI enable bit also gates the power-management I/O base: the base is decoded only while the bit is set, and it reads as zero otherwise.

Top module: `sci_steer`

## Requirements
- R1: The select code in control bits [2:0] maps code 0 to pin 9, code 1 to pin 10, code 2 to pin 11, code 4 to pin 20 and code 5 to pin 21. For these codes, `tgt_valid` is 1 in the cycle after the write edge.
- R2: Select codes 3, 6 and 7 are reserved. With a reserved code, `tgt_valid` and `tgt_level` are both 0 and `tgt_apic` is 0.
- R3: `tgt_level` follows `sci_in` with one register stage while the target is valid. Holding `sci_in` at the same value leaves `tgt_level` unchanged.
- R4: When the decoded target changes (including a change to a reserved code) while `tgt_level` is 1, the first cycle after the write edge shows the old pin with `tgt_level` 0. The next cycle shows the new pin with the current SCI level.
- R5: When the target changes while `tgt_level` is 0, the new pin appears in the cycle right after the write edge, with no extra gap cycle.
- R6: `tgt_apic` is 1 exactly when the valid target is 16 or above (pins 20 and 21). It is 0 for the legacy pins 9 to 11.
- R7: `pm_io_en` equals control bit 7. `pm_base_eff` equals `pm_base_raw` with its low ALIGN_BITS bits cleared (default 7) while bit 7 is set, and equals 0 while bit 7 is clear. Both values take effect in the cycle after the write edge.
- R8: Reset clears the control byte to 0x00, which gives pin 9 with `tgt_valid` 1. Reset also clears the stored SCI level to 0 and clears `pm_io_en`.
- R9: A write that keeps the same target while the SCI is asserted, for example one that only toggles bit 7, does not interrupt `tgt_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sci_in | input | 1 | SCI level from power-management logic |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data: [2:0] select, [7] ACPI enable |
| pm_base_raw | input | 16 | Programmed power-management I/O base |
| tgt_pin | output | 5 | Target interrupt pin number |
| tgt_valid | output | 1 | Target pin is routed (select code not reserved) |
| tgt_apic | output | 1 | Target is on the APIC side (pin 16 or above) |
| tgt_level | output | 1 | SCI level driven on the target pin |
| pm_io_en | output | 1 | Power-management I/O decode enabled |
| pm_base_eff | output | 16 | Effective power-management I/O base, 0 when disabled |

## Verification
The bench retargets while the SCI is high, both to another valid pin and to a reserved code. A design without the gap cycle would move the high level straight onto the new pin. A design without the old-pin hold would drop the wrong line. It also rewrites the control byte with the same target while the SCI is high. A design that retargets on every write would show a false low pulse there. It also checks the reserved codes, where a careless decoder leaks the level onto some pin, and the enable gating of the I/O base, where a base that is not gated stays visible after the enable bit clears.

// File: rtl/sci_steer_pkg.sv
package sci_steer_pkg;

    localparam int PIN_W       = 5;
    localparam int SEL_W       = 3;
    localparam int CTL_W       = 8;
    localparam int EN_BIT      = 7;
    localparam int LEGACY_PINS = 16;

    typedef logic [PIN_W-1:0] pin_t;

    typedef struct packed {
        pin_t pin;
        logic ok;
    } route_t;

    typedef enum logic {
        ST_LIVE = 1'b0,
        ST_DROP = 1'b1
    } route_st_t;

    function automatic route_t decode_sel(input logic [SEL_W-1:0] sel);
        route_t r;
        r.ok  = 1'b1;
        r.pin = pin_t'(9);
        case (sel)
            3'd0: r.pin = pin_t'(9);
            3'd1: r.pin = pin_t'(10);
            3'd2: r.pin = pin_t'(11);
            3'd4: r.pin = pin_t'(20);
            3'd5: r.pin = pin_t'(21);
            default: begin
                r.pin = '0;
                r.ok  = 1'b0;
            end
        endcase
        return r;
    endfunction

    function automatic logic on_apic_side(input pin_t p);
        return 32'(p) >= LEGACY_PINS;
    endfunction

endpackage

// File: rtl/sci_ctl_reg.sv
module sci_ctl_reg
    import sci_steer_pkg::*;
#(
    parameter int BASE_W     = 16,
    parameter int ALIGN_BITS = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CTL_W-1:0]  wdata,
    input  logic [BASE_W-1:0] base_raw,
    output logic [CTL_W-1:0]  ctl_next,
    output logic              pm_en,
    output logic [BASE_W-1:0] base_eff
);
    localparam logic [BASE_W-1:0] BASE_MASK = ~((BASE_W)'((1 << ALIGN_BITS) - 1));

    logic [CTL_W-1:0] ctl_q;

    assign ctl_next = we ? wdata : ctl_q;

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_next;
    end

    assign pm_en    = ctl_q[EN_BIT];
    assign base_eff = pm_en ? (base_raw & BASE_MASK) : '0;

    a_r7_base_gated: assert property (@(posedge clk) disable iff (rst)
        !pm_en |-> (base_eff == '0));

    a_r7_en_follows_write: assert property (@(posedge clk) disable iff (rst)
        we |=> (pm_en == $past(wdata[EN_BIT])));

endmodule

// File: rtl/sci_route_fsm.sv
module sci_route_fsm
    import sci_steer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel_next,
    input  logic             sci_in,
    output pin_t             pin,
    output logic             valid,
    output logic             apic,
    output logic             level
);
    route_st_t st;
    route_t    nr;
    logic      moving;

    assign nr     = decode_sel(sel_next);
    assign moving = level && ((nr.pin != pin) || !nr.ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_LIVE;
            pin   <= pin_t'(9);
            valid <= 1'b1;
            level <= 1'b0;
        end else begin
            case (st)
                ST_LIVE: begin
                    if (moving) begin
                        st    <= ST_DROP;
                        level <= 1'b0;
                    end else begin
                        pin   <= nr.pin;
                        valid <= nr.ok;
                        level <= sci_in & nr.ok;
                    end
                end
                default: begin
                    st    <= ST_LIVE;
                    pin   <= nr.pin;
                    valid <= nr.ok;
                    level <= sci_in & nr.ok;
                end
            endcase
        end
    end

    assign apic = valid && on_apic_side(pin);

    a_r4_no_overlap: assert property (@(posedge clk) disable iff (rst)
        level |=> (!level || $stable(pin)));

    a_r2_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
        !valid |-> (!level && !apic));

    a_r1_pin_legal: assert property (@(posedge clk) disable iff (rst)
        valid |-> (pin == 5'd9 || pin == 5'd10 || pin == 5'd11 ||
                   pin == 5'd20 || pin == 5'd21));

    a_r4_drop_is_low: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DROP) |-> (!level && valid));

endmodule

// File: rtl/sci_steer.sv
module sci_steer
    import sci_steer_pkg::*;
#(
    parameter int BASE_W     = 16,
    parameter int ALIGN_BITS = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sci_in,
    input  logic              ctl_we,
    input  logic [7:0]        ctl_wdata,
    input  logic [BASE_W-1:0] pm_base_raw,
    output logic [4:0]        tgt_pin,
    output logic              tgt_valid,
    output logic              tgt_apic,
    output logic              tgt_level,
    output logic              pm_io_en,
    output logic [BASE_W-1:0] pm_base_eff
);
    logic [CTL_W-1:0] ctl_next;
    pin_t             pin_w;

    sci_ctl_reg #(
        .BASE_W     (BASE_W),
        .ALIGN_BITS (ALIGN_BITS)
    ) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .we       (ctl_we),
        .wdata    (ctl_wdata),
        .base_raw (pm_base_raw),
        .ctl_next (ctl_next),
        .pm_en    (pm_io_en),
        .base_eff (pm_base_eff)
    );

    sci_route_fsm u_route (
        .clk      (clk),
        .rst      (rst),
        .sel_next (ctl_next[SEL_W-1:0]),
        .sci_in   (sci_in),
        .pin      (pin_w),
        .valid    (tgt_valid),
        .apic     (tgt_apic),
        .level    (tgt_level)
    );

    assign tgt_pin = pin_w;

    a_r6_apic_range: assert property (@(posedge clk) disable iff (rst)
        tgt_apic |-> (tgt_valid && tgt_pin >= 5'd16));

endmodule

// File: tb/sci_steer_bench.sv
module sci_steer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sci_in = 1'b0;
    logic        ctl_we = 1'b0;
    logic [7:0]  ctl_wdata = '0;
    logic [15:0] pm_base_raw = 16'h0000;
    logic [4:0]  tgt_pin;
    logic        tgt_valid, tgt_apic, tgt_level, pm_io_en;
    logic [15:0] pm_base_eff;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sci_steer u_sci_steer (
        .clk(clk), .rst(rst), .sci_in(sci_in), .ctl_we(ctl_we),
        .ctl_wdata(ctl_wdata), .pm_base_raw(pm_base_raw),
        .tgt_pin(tgt_pin), .tgt_valid(tgt_valid), .tgt_apic(tgt_apic),
        .tgt_level(tgt_level), .pm_io_en(pm_io_en), .pm_base_eff(pm_base_eff)
    );

    // reference model, built from the requirements
    logic [7:0] m_ctl;
    int         m_pin;
    logic       m_valid, m_lvl, m_gap;

    function automatic int want_pin(input logic [2:0] s);
        if (s == 3'd0) return 9;
        if (s == 3'd1) return 10;
        if (s == 3'd2) return 11;
        if (s == 3'd4) return 20;
        if (s == 3'd5) return 21;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ctl = 8'h00; m_pin = 9; m_valid = 1'b1; m_lvl = 1'b0; m_gap = 1'b0;
        end else begin
            logic [7:0] nc;
            int np;
            nc = ctl_we ? ctl_wdata : m_ctl;
            np = want_pin(nc[2:0]);
            if (!m_gap && m_lvl && (np != m_pin)) begin
                m_gap = 1'b1; m_lvl = 1'b0;             // R4 gap cycle
            end else begin
                m_gap = 1'b0;
                m_valid = (np >= 0);
                m_pin = np;
                m_lvl = sci_in && (np >= 0);
            end
            m_ctl = nc;
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2 valid", tgt_valid, m_valid);
        chk("R3/R4 level", tgt_level, m_lvl);
        if (m_valid) chk("R1 pin", tgt_pin, m_pin);
        chk("R6 apic", tgt_apic, m_valid && m_pin >= 16);
        chk("R7 pm_en", pm_io_en, m_ctl[7]);
        chk("R7 base", pm_base_eff, m_ctl[7] ? (pm_base_raw & 16'hFF80) : 0);
    endtask

    task automatic cyc(input logic s, input logic we, input logic [7:0] wd);
        sci_in = s; ctl_we = we; ctl_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5C1_0007;
        void'($urandom(seed));
        pm_base_raw = 16'hB07F;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R8 reset state
        chk("R8 pin", tgt_pin, 9);
        chk("R8 valid", tgt_valid, 1);
        chk("R8 level", tgt_level, 0);
        chk("R8 pm_en", pm_io_en, 0);
        chk("R8 base", pm_base_eff, 0);

        // R1 each valid code, R5 immediate move when low
        cyc(1'b0, 1'b1, 8'h04);
        chk("R5 pin20", tgt_pin, 20);
        chk("R6 apic20", tgt_apic, 1);
        cyc(1'b0, 1'b1, 8'h01); chk("R1 pin10", tgt_pin, 10);
        cyc(1'b0, 1'b1, 8'h02); chk("R1 pin11", tgt_pin, 11);
        chk("R6 legacy", tgt_apic, 0);
        cyc(1'b0, 1'b1, 8'h05); chk("R1 pin21", tgt_pin, 21);
        // R2 reserved codes with sci high
        cyc(1'b1, 1'b1, 8'h03);
        chk("R2 res3 valid", tgt_valid, 0);
        chk("R2 res3 level", tgt_level, 0);
        cyc(1'b1, 1'b1, 8'h06); chk("R2 res6 level", tgt_level, 0);
        cyc(1'b1, 1'b1, 8'h07); chk("R2 res7 valid", tgt_valid, 0);

        // R3 level follows, held
        cyc(1'b1, 1'b1, 8'h00);
        chk("R3 rise", tgt_level, 1);
        cyc(1'b1, 1'b0, 8'h00); chk("R3 hold", tgt_level, 1);
        cyc(1'b0, 1'b0, 8'h00); chk("R3 fall", tgt_level, 0);
        cyc(1'b1, 1'b0, 8'h00);

        // R4 retarget while asserted: 9 -> 21
        cyc(1'b1, 1'b1, 8'h05);
        chk("R4 gap pin", tgt_pin, 9);
        chk("R4 gap level", tgt_level, 0);
        cyc(1'b1, 1'b0, 8'h00);
        chk("R4 new pin", tgt_pin, 21);
        chk("R4 new level", tgt_level, 1);

        // R9 same target rewrite with enable toggle
        cyc(1'b1, 1'b1, 8'h85);
        chk("R9 level kept", tgt_level, 1);
        chk("R7 enabled", pm_io_en, 1);
        chk("R7 base val", pm_base_eff, 16'hB000);
        cyc(1'b1, 1'b1, 8'h05);
        chk("R9 level kept2", tgt_level, 1);
        chk("R7 base off", pm_base_eff, 0);

        // R4 retarget to reserved while asserted
        cyc(1'b1, 1'b1, 8'h87);
        chk("R4 gap to res", tgt_level, 0);
        chk("R4 gap to res pin", tgt_pin, 21);
        cyc(1'b1, 1'b0, 8'h00);
        chk("R4 res valid", tgt_valid, 0);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic s, w;
            logic [7:0] d;
            s = ($urandom % 4) != 0;
            w = ($urandom % 5) == 0;
            d = 8'($urandom);
            if (($urandom % 16) == 0) pm_base_raw = 16'($urandom);
            cyc(s, w, d);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule